// File: doc/BRIEF.md
# Interleaving DRAM Bank Address Mapper

The mapper turns a CPU byte address into a DRAM access for a controller that drives four 16-bit-wide banks. It produces the target bank, an 11-bit row address, an 11-bit column address and the byte-lane bit. Each bank has its own enable, base and geometry code. Global control bits choose how address bits are spread over row and column: page mode or non-page mode. They also choose whether consecutive blocks of memory rotate across a pair of banks or across all four banks. A translation that lands nowhere usable comes out with its ok flag low.

Addresses arrive on a valid/ready stream. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result is on the output one cycle later with `out_valid` high. The result stays there unchanged until the consumer raises `out_ready`. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. This gives full throughput with one register of buffering. Configuration is written through a plain synchronous write port.

Top module: `dram_ilv_mapper`

## Requirements
- R1: After reset `out_valid` is low and `out_ok`, `out_bank`, `out_row`, `out_col` and `out_lane` are zero. All configuration registers are zero.
- R2: Geometry codes 0, 1, 2 and 3 set N = 8, 9, 10 and 11 row/column bits, which gives bank sizes of 128 KiB, 512 KiB, 2 MiB and 8 MiB. A bank's base is its base register times 128 KiB. Bank i is searched only when enable bit 2*i is set. Without interleave, an address hits a bank when it is at or above the base and below base plus the bank size. An address that hits no bank gives `out_ok` = 0.
- R3: In page mode, with offset o = address − base, the column is o[11:1]. Row bits 8, 9 and 10 are o[18], o[20] and o[22]. Row bits j < m, where m = geometry code + interleave bits, come from o[17], o[19], o[21], o[23] and o[24] in turn. Every other row bit j ≤ 7 is o[9+j]. Row and column are both masked to N bits, and the lane bit is o[0].
- R4: In non-page mode without interleave, the row is o[11:1]. The column is built by the rule R3 gives for the row, using m = geometry code. Both are masked to N bits.
- R5: Control bit 10 interleaves across all four banks. Only bank 0 is searched, and its window is four times its size. The target bank is o[10+g:9+g], where g is the geometry code. When page mode is off, the result has `out_ok` = 0.
- R6: Control bit 8 (banks 0/1) and bit 9 (banks 2/3) interleave one pair, which doubles the window of the pair's lower bank. The target is that bank ORed with one select bit. In page mode the select bit is o[9+g]. In non-page mode it is o[1]: the row is then o[13] in bit 0 and o[j+1] in bit j ≥ 1, and column bit 4 takes o[12] for code 3 and the next fill bit otherwise.
- R7: A translation is rejected when the target bank is disabled or is not marked populated.
- R8: Banks are packed in physical space in index order, each populated bank taking its geometry size. The physical address is the target's packed start plus (row << (N+1)) | (col << 1) | lane. A translation is rejected when that address is at or above the limit register times 128 KiB.
- R9: Banks are searched in ascending order and the first hit wins. The upper bank of an active pair, and banks 1 to 3 under four-way interleave, are never searched.
- R10: When `out_ok` is low, `out_bank`, `out_row`, `out_col` and `out_lane` are zero.
- R11: The result appears one cycle after acceptance. While `out_valid` is high and `out_ready` is low, every output holds and `in_ready` is low.
- R12: The configuration write port uses these offsets. Offset 0 is control: bit 8 pair 0/1, bit 9 pair 2/3, bit 10 four-way, bit 11 page mode. Offset 1 holds the enables in bits 0, 2, 4 and 6. Offset 2 holds the geometry codes in bits [2i+1:2i] and the populated flags in bits 8+i. Offset 3 is the limit. Offsets 4 to 7 are the bases of banks 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wdata | input | 16 | Configuration write data |
| in_valid | input | 1 | Address request valid |
| in_ready | output | 1 | Mapper can take a request |
| in_addr | input | ADDR_W (26) | CPU byte address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ok | output | 1 | Translation is usable |
| out_bank | output | 2 | Target bank |
| out_row | output | 11 | Row address |
| out_col | output | 11 | Column address |
| out_lane | output | 1 | Byte-lane bit |

## Verification
The bench builds the mapper with its default 26-bit address. That width reaches offset bit 24, which is needed for the largest geometry under four-way interleave. It also allows an 8 MiB bank together with a limit register wide enough to hold 32 MiB. The vector walk covers page and non-page scrambling for the smallest and largest geometries, both interleave widths and bank-select ORing. It also covers window misses, unpopulated and disabled targets, the limit cut-off and first-match priority. Directed steps cover reset and holding the output under back-pressure.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;
  localparam int NBANK   = 4;
  localparam int UNIT_SH = 17;   // base and limit granule: 128 KiB
  localparam int RC_W    = 11;   // widest row/column

  typedef logic [1:0] geo_t;

  typedef struct packed {
    logic page;
    logic ilv4;
    logic ilv23;
    logic ilv01;
  } ctrl_t;

  // offset bit that fills scrambled row/column position j
  function automatic int fill_pos(input int j);
    case (j)
      0:       return 17;
      1:       return 19;
      2:       return 21;
      3:       return 23;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/amap_cfg.sv
module amap_cfg
  import dram_map_pkg::*;
#(
  parameter int ADDR_W = 26,
  localparam int BASE_W = ADDR_W - UNIT_SH,
  localparam int LIM_W  = BASE_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [2:0]                    cfg_addr,
  input  logic [15:0]                   cfg_wdata,
  output ctrl_t                         ctrl,
  output logic [NBANK-1:0]              bank_en,
  output logic [NBANK-1:0]              bank_pop,
  output logic [NBANK-1:0][1:0]         bank_geo,
  output logic [NBANK-1:0][BASE_W-1:0]  bank_base,
  output logic [LIM_W-1:0]              limit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      bank_en   <= '0;
      bank_pop  <= '0;
      bank_geo  <= '0;
      bank_base <= '0;
      limit     <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: ctrl <= cfg_wdata[11:8];
        3'd1: for (int i = 0; i < NBANK; i++) bank_en[i] <= cfg_wdata[2*i];
        3'd2: begin
          for (int i = 0; i < NBANK; i++) bank_geo[i] <= cfg_wdata[2*i +: 2];
          bank_pop <= cfg_wdata[8 +: NBANK];
        end
        3'd3: limit <= cfg_wdata[LIM_W-1:0];
        default: bank_base[cfg_addr[1:0]] <= cfg_wdata[BASE_W-1:0];
      endcase
    end
  end

  // R12
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd0) |=> (ctrl == $past(cfg_wdata[11:8])));
endmodule

// File: rtl/amap_window.sv
module amap_window
  import dram_map_pkg::*;
#(
  parameter int ADDR_W = 26,
  localparam int BASE_W = ADDR_W - UNIT_SH
) (
  input  logic              searchable,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  input  logic [1:0]        geo,
  input  logic [1:0]        ilv,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  logic [ADDR_W-1:0] start;
  int unsigned       span_sh;

  always_comb begin
    start   = {base, {UNIT_SH{1'b0}}};
    offset  = addr - start;
    span_sh = UNIT_SH + 2 * int'(geo) + int'(ilv);
    hit     = searchable && (addr >= start) && ((offset >> span_sh) == '0);
  end
endmodule

// File: rtl/amap_scramble.sv
module amap_scramble
  import dram_map_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic [ADDR_W-1:0] off,
  input  logic [1:0]        geo,
  input  logic [1:0]        ilv,
  input  logic              page,
  output logic [RC_W-1:0]   row,
  output logic [RC_W-1:0]   col,
  output logic [1:0]        sel,
  output logic              lane,
  output logic              bad
);
  logic [RC_W-1:0] row_r, col_r, mask;
  int              m;

  always_comb begin
    m     = int'(geo) + int'(ilv);
    row_r = '0;
    col_r = '0;
    sel   = '0;
    if (page) begin
      for (int j = 0; j < 8; j++)
        row_r[j] = (j < m) ? off[fill_pos(j)] : off[9 + j];
      row_r[10:8] = {off[22], off[20], off[18]};
      col_r = off[11:1];
      if (ilv != 2'd0) sel[0] = off[9 + int'(geo)];
      if (ilv == 2'd2) sel[1] = off[10 + int'(geo)];
    end else begin
      if (ilv == 2'd1) begin
        sel[0]   = off[1];
        row_r[0] = off[13];
        for (int j = 1; j < RC_W; j++) row_r[j] = off[j + 1];
      end else begin
        row_r = off[11:1];
      end
      for (int j = 0; j < 8; j++)
        col_r[j] = (j < int'(geo)) ? off[fill_pos(j)] : off[9 + j];
      if (ilv == 2'd1)
        col_r[4] = (geo == 2'd3) ? off[12] : off[fill_pos(int'(geo))];
      col_r[10:8] = {off[22], off[20], off[18]};
    end
    mask = {RC_W{1'b1}} >> (2'd3 - geo);
    row  = row_r & mask;
    col  = col_r & mask;
    lane = off[0];
    bad  = (ilv == 2'd2) && !page;
  end
endmodule

// File: rtl/dram_ilv_mapper.sv
module dram_ilv_mapper
  import dram_map_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_ok,
  output logic [1:0]        out_bank,
  output logic [10:0]       out_row,
  output logic [10:0]       out_col,
  output logic              out_lane
);
  localparam int BASE_W = ADDR_W - UNIT_SH;
  localparam int LIM_W  = BASE_W + 1;
  localparam int PW     = ADDR_W + 1;

  ctrl_t                        ctrl;
  logic [NBANK-1:0]             bank_en, bank_pop, searchable, hit;
  logic [NBANK-1:0][1:0]        bank_geo, bank_ilv;
  logic [NBANK-1:0][BASE_W-1:0] bank_base;
  logic [NBANK-1:0][ADDR_W-1:0] bank_off;
  logic [LIM_W-1:0]             limit;

  amap_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .ctrl, .bank_en, .bank_pop, .bank_geo, .bank_base, .limit
  );

  // per-bank window decode; interleave groups hide their upper members
  for (genvar i = 0; i < NBANK; i++) begin : g_win
    localparam bit PAIR_HI = (i % 2) == 1;
    logic pair_on;
    assign pair_on = (i < 2) ? ctrl.ilv01 : ctrl.ilv23;
    assign bank_ilv[i] = ctrl.ilv4 ? 2'd2 : (pair_on ? 2'd1 : 2'd0);
    assign searchable[i] = bank_en[i]
                         && !(ctrl.ilv4 && i != 0)
                         && !(!ctrl.ilv4 && pair_on && PAIR_HI);
    amap_window #(.ADDR_W(ADDR_W)) u_win (
      .searchable(searchable[i]), .addr(in_addr), .base(bank_base[i]),
      .geo(bank_geo[i]), .ilv(bank_ilv[i]), .hit(hit[i]), .offset(bank_off[i])
    );
  end

  // first hit in ascending order
  logic              found;
  logic [1:0]        idx;
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NBANK - 1; i >= 0; i--)
      if (hit[i]) begin
        found = 1'b1;
        idx   = 2'(i);
      end
  end

  logic [RC_W-1:0] s_row, s_col;
  logic [1:0]      s_sel;
  logic            s_lane, s_bad;

  amap_scramble #(.ADDR_W(ADDR_W)) u_scr (
    .off(bank_off[idx]), .geo(bank_geo[idx]), .ilv(bank_ilv[idx]),
    .page(ctrl.page), .row(s_row), .col(s_col), .sel(s_sel),
    .lane(s_lane), .bad(s_bad)
  );

  // packed physical starts of populated banks
  logic [NBANK-1:0][PW-1:0] pbase;
  logic [PW-1:0]            acc;
  always_comb begin
    acc = '0;
    for (int i = 0; i < NBANK; i++) begin
      pbase[i] = acc;
      if (bank_pop[i]) acc = acc + (PW'(1) << (UNIT_SH + 2 * int'(bank_geo[i])));
    end
  end

  logic [1:0]    target;
  logic [PW-1:0] rebuilt, phys, lim_bytes;
  logic          ok_c;
  int unsigned   nb;
  always_comb begin
    target    = idx | s_sel;
    nb        = 8 + int'(bank_geo[idx]);
    rebuilt   = (PW'(s_row) << (nb + 1)) | (PW'(s_col) << 1) | PW'(s_lane);
    phys      = pbase[target] + rebuilt;
    lim_bytes = {limit, {UNIT_SH{1'b0}}};
    ok_c      = found && !s_bad && bank_en[target] && bank_pop[target]
             && (phys < lim_bytes);
  end

  // one-entry output stage
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ok    <= 1'b0;
      out_bank  <= '0;
      out_row   <= '0;
      out_col   <= '0;
      out_lane  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_ok    <= ok_c;
      out_bank  <= ok_c ? target : 2'd0;
      out_row   <= ok_c ? s_row  : '0;
      out_col   <= ok_c ? s_col  : '0;
      out_lane  <= ok_c && s_lane;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  zero_when_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ok) |-> (out_bank == 2'd0 && out_row == '0 && out_col == '0 && !out_lane));
  // R11
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ok) && $stable(out_bank)
      && $stable(out_row) && $stable(out_col) && $stable(out_lane)));
  // R11
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R11
  one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R5
  fourway_needs_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && ctrl.ilv4 && !ctrl.page) |=> !out_ok);
  // R9
  single_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit & searchable) || (found && hit[idx] && (hit & ((4'b1 << idx) - 4'b1)) == '0));
endmodule

// File: tb/sim_dram_ilv_mapper.sv
module sim_dram_ilv_mapper;
  localparam int ADDR_W = 26;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_addr = '0;
  logic [15:0]       cfg_wdata = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [ADDR_W-1:0] in_addr = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic              out_ok;
  logic [1:0]        out_bank;
  logic [10:0]       out_row, out_col;
  logic              out_lane;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dram_ilv_mapper #(.ADDR_W(ADDR_W)) u0 (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .in_valid, .in_ready,
    .in_addr, .out_valid, .out_ready, .out_ok, .out_bank, .out_row,
    .out_col, .out_lane
  );

  typedef struct packed {
    logic [15:0] tag;
    logic [11:0] ctrl;
    logic [7:0]  en;
    logic [11:0] sz;
    logic [9:0]  lim;
    logic [35:0] bases;   // {b3,b2,b1,b0}, 9 bits each
    logic [25:0] addr;
    logic        ok;
    logic [1:0]  bank;
    logic [10:0] row;
    logic [10:0] col;
    logic        lane;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{"R2", 12'h800, 8'h55, 12'hF00, 10'd4,  {9'd3,9'd2,9'd1,9'd0}, 26'h0000000, 1'b1, 2'd0, 11'h000, 11'h000, 1'b0},
    '{"R3", 12'h800, 8'h55, 12'hF00, 10'd4,  {9'd3,9'd2,9'd1,9'd0}, 26'h0021235, 1'b1, 2'd1, 11'h009, 11'h01A, 1'b1},
    '{"R4", 12'h000, 8'h55, 12'hF00, 10'd4,  {9'd3,9'd2,9'd1,9'd0}, 26'h0021235, 1'b1, 2'd1, 11'h01A, 11'h009, 1'b1},
    '{"R2", 12'h800, 8'h55, 12'hF00, 10'd4,  {9'd3,9'd2,9'd1,9'd0}, 26'h0080000, 1'b0, 2'd0, 11'h000, 11'h000, 1'b0},
    '{"R8", 12'h800, 8'h55, 12'hF00, 10'd3,  {9'd3,9'd2,9'd1,9'd0}, 26'h0061235, 1'b0, 2'd0, 11'h000, 11'h000, 1'b0},
    '{"R5", 12'hC00, 8'h55, 12'hF00, 10'd4,  {9'd0,9'd0,9'd0,9'd0}, 26'h0040E02, 1'b1, 2'd3, 11'h004, 11'h001, 1'b0},
    '{"R5", 12'h400, 8'h55, 12'hF00, 10'd4,  {9'd0,9'd0,9'd0,9'd0}, 26'h0040E02, 1'b0, 2'd0, 11'h000, 11'h000, 1'b0},
    '{"R7", 12'hC00, 8'h15, 12'hF00, 10'd4,  {9'd0,9'd0,9'd0,9'd0}, 26'h0040E02, 1'b0, 2'd0, 11'h000, 11'h000, 1'b0},
    '{"R6", 12'h100, 8'h55, 12'hF00, 10'd4,  {9'd3,9'd2,9'd0,9'd0}, 26'h0002006, 1'b1, 2'd1, 11'h003, 11'h000, 1'b0},
    '{"R9", 12'h100, 8'h55, 12'hF00, 10'd4,  {9'd3,9'd2,9'd0,9'd0}, 26'h0040003, 1'b1, 2'd2, 11'h001, 11'h000, 1'b1},
    '{"R3", 12'h800, 8'h01, 12'h103, 10'd64, {9'd0,9'd0,9'd0,9'd0}, 26'h0200402, 1'b1, 2'd0, 11'h004, 11'h201, 1'b0},
    '{"R2", 12'h800, 8'h01, 12'h103, 10'd64, {9'd0,9'd0,9'd0,9'd0}, 26'h0800000, 1'b0, 2'd0, 11'h000, 11'h000, 1'b0},
    '{"R7", 12'h800, 8'h55, 12'hD00, 10'd4,  {9'd3,9'd2,9'd1,9'd0}, 26'h0021235, 1'b0, 2'd0, 11'h000, 11'h000, 1'b0},
    '{"R9", 12'h800, 8'h55, 12'hF00, 10'd4,  {9'd3,9'd2,9'd0,9'd0}, 26'h0001235, 1'b1, 2'd0, 11'h009, 11'h01A, 1'b1},
    '{"R6", 12'h900, 8'h55, 12'hF00, 10'd4,  {9'd3,9'd2,9'd0,9'd0}, 26'h0000203, 1'b1, 2'd1, 11'h000, 11'h001, 1'b1}
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load(input vec_t v);
    wr(3'd0, {4'h0, v.ctrl});
    wr(3'd1, {8'h00, v.en});
    wr(3'd2, {4'h0, v.sz});
    wr(3'd3, {6'h00, v.lim});
    for (int b = 0; b < 4; b++) wr(3'(4 + b), {7'h00, v.bases[9*b +: 9]});
  endtask

  // present one address; leaves the clock at the negedge after acceptance
  task automatic send(input logic [25:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "out_valid", 32'(out_valid), 0);
    check("R1", "fields", {out_ok, out_bank, out_row, out_col, out_lane}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 configuration cleared: any address is rejected
    send(26'h0000100);
    check("R1", "ok after reset", 32'(out_ok), 0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      load(v);
      send(v.addr);
      check(string'(v.tag), "valid", 32'(out_valid), 1);
      check(string'(v.tag), $sformatf("ok #%0d", k), 32'(out_ok), 32'(v.ok));
      check(string'(v.tag), $sformatf("bank #%0d", k), 32'(out_bank), 32'(v.bank));
      check(string'(v.tag), $sformatf("row #%0d", k), 32'(out_row), 32'(v.row));
      check(string'(v.tag), $sformatf("col #%0d", k), 32'(out_col), 32'(v.col));
      check(string'(v.tag), $sformatf("lane #%0d", k), 32'(out_lane), 32'(v.lane));
      if (!v.ok) check("R10", "zeroed fields", {out_bank, out_row, out_col, out_lane}, 0);
    end

    // R11 back-pressure: config still from last vector
    @(negedge clk);
    out_ready = 1'b0;
    send(26'h0000203);
    check("R11", "valid under stall", 32'(out_valid), 1);
    check("R11", "in_ready under stall", 32'(in_ready), 0);
    in_valid = 1'b1; in_addr = 26'h0000000;
    repeat (2) @(negedge clk);
    check("R11", "held col", 32'(out_col), 32'h001);
    check("R11", "held bank", 32'(out_bank), 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11", "second result col", 32'(out_col), 0);
    check("R11", "second result bank", 32'(out_bank), 0);
    @(negedge clk);
    check("R11", "drained", 32'(out_valid), 0);

    // R12 control read through behaviour: clear page mode, 4-way now rejected
    wr(3'd0, 16'h0400);
    send(26'h0040E02);
    check("R12", "page bit cleared", 32'(out_ok), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule